// File: doc/BRIEF.md
# Dual-Die NAND Read-Path Device Model

This block models the device end of a small NAND-style flash that only supports reads. It has two dies behind one shared multiplexed 8-bit bus. Each die has its own active-low chip enable and its own ready output. A host drives command-latch and address-latch qualifiers, an active-low read strobe and an active-low write strobe. All of them are asynchronous to the block's clock. The block samples them through a two-stage synchroniser and acts on the falling edges of the strobes.

The selected die accepts a reset command or one of three read-mode commands. It then takes three address bytes: a column byte, which the read mode biases into a different region of the 528-byte page, and a page number sent high byte first. Each read strobe returns one byte on the bus and advances the address linearly across page boundaries. The address wraps at the end of the storage. Storage holds a parameterised number of pages per die and reads 0xFF until it is written. A backdoor write port presets the contents before a test. Malformed bus sequences raise a one-cycle error pulse and leave the die's mode, address-cycle count and address unchanged.

Top module: `nand_rd_model`

## Requirements
- R1: The die whose chip enable is low is selected. With both enables low, die 0 (bit 0 of `ce_n`) is selected. With both high, bus activity changes no output and no die state.
- R2: Out of reset, `ready`, `bus_oe` and `err` are 0. A synchronised sample with a die selected and both strobes high sets that die's `ready` bit and clears `bus_oe`. A sample with a die selected and any strobe low clears that die's `ready` bit.
- R3: On a write-strobe falling edge with `cle` high, command byte 0xFF puts the die in the wait state. Command bytes 0x00, 0x01 and 0x50 select read modes 1, 2 and 3 and reset the address-cycle count to 0.
- R4: On a write-strobe falling edge with `ale` high (and `cle` low) in a read mode, the first address byte sets the address to the byte plus a column bias: 0 in mode 1, 0x100 in mode 2, 0x200 in mode 3.
- R5: The second address byte adds byte × PAGE_BYTES × 256 and the third adds byte × PAGE_BYTES (page number high byte first, PAGE_BYTES = 528 by default).
- R6: On a read-strobe falling edge with both latches low, the selected die places the byte at its current address on `bus_out`, raises `bus_oe`, and then increments the address. The address continues across page boundaries.
- R7: A location never written through the backdoor port reads 0xFF. A backdoor write (`bd_we`, `bd_die`, `bd_addr`, `bd_data`) sets the byte that later reads return.
- R8: `err` pulses for one cycle, with die mode, address-cycle count and address unchanged, on any of these: an unknown command byte, a fourth address byte, an address byte in the wait state, a read-strobe falling edge with a latch high, a write-strobe falling edge with both latches low, or both strobes falling in the same sample.
- R9: All address arithmetic, both address building and read increments, is taken modulo DEPTH = PAGE_BYTES × NUM_PAGES, so the address never reaches DEPTH.
- R10: An input change made between clock edges first affects the outputs after the third rising edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | NUM_DIES | Active-low chip enables, one per die |
| cle | input | 1 | Command-latch qualifier |
| ale | input | 1 | Address-latch qualifier |
| re_n | input | 1 | Active-low read strobe |
| we_n | input | 1 | Active-low write strobe |
| bus_in | input | 8 | Bus byte driven by the host |
| bus_out | output | 8 | Byte returned by a read |
| bus_oe | output | 1 | High while the device drives the bus |
| ready | output | NUM_DIES | Per-die ready |
| err | output | 1 | One-cycle pulse on a malformed sequence |
| bd_we | input | 1 | Backdoor write enable |
| bd_die | input | DW | Backdoor target die |
| bd_addr | input | AW | Backdoor byte address |
| bd_data | input | 8 | Backdoor byte |

## Verification
The hardest case to produce is a die whose state must provably not move. This covers the non-selected die while both enables are low, and any die after a malformed sequence. The only way to see the address from outside is to read from it. So the stimulus first parks die 1 at a known patterned address. It then runs a full command, address and read sequence with both enables low, and after that reads die 1 again to confirm it continues from where it was parked. After each error case the bench issues a plain read, which shows that the address stayed put. A behavioural model in the bench, fed by a queue of sampled inputs, follows the synchroniser latency and is compared on every clock.

// File: rtl/nand_pkg.sv
package nand_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_RD1  = 2'd1,
        ST_RD2  = 2'd2,
        ST_RD3  = 2'd3
    } die_mode_e;

    localparam logic [7:0] CMD_RESET = 8'hFF;
    localparam logic [7:0] CMD_RD1   = 8'h00;
    localparam logic [7:0] CMD_RD2   = 8'h01;
    localparam logic [7:0] CMD_RD3   = 8'h50;

    localparam int unsigned BIAS_RD2 = 32'h100;
    localparam int unsigned BIAS_RD3 = 32'h200;
    localparam int unsigned HI_SHIFT = 256;

    // Strobe and data lines as sampled from the host side.
    typedef struct packed {
        logic       cle;
        logic       ale;
        logic       re_n;
        logic       we_n;
        logic [7:0] data;
    } bus_smp_t;

    localparam bus_smp_t SMP_IDLE = '{cle: 1'b0, ale: 1'b0, re_n: 1'b1,
                                      we_n: 1'b1, data: 8'h00};

    // Edge events derived from the synchronised samples.
    typedef struct packed {
        logic       we_fall;
        logic       re_fall;
        logic       cle;
        logic       ale;
        logic [7:0] data;
    } bus_evt_t;

    function automatic logic cmd_known(input logic [7:0] b);
        return (b == CMD_RESET) || (b == CMD_RD1) ||
               (b == CMD_RD2)   || (b == CMD_RD3);
    endfunction

    function automatic die_mode_e cmd_mode(input logic [7:0] b);
        case (b)
            CMD_RD1: return ST_RD1;
            CMD_RD2: return ST_RD2;
            CMD_RD3: return ST_RD3;
            default: return ST_WAIT;
        endcase
    endfunction

    function automatic int unsigned col_bias(input die_mode_e m);
        case (m)
            ST_RD2:  return BIAS_RD2;
            ST_RD3:  return BIAS_RD3;
            default: return 0;
        endcase
    endfunction

    function automatic int unsigned add_mod(input int unsigned base,
                                            input int unsigned inc,
                                            input int unsigned depth);
        return (base + (inc % depth)) % depth;
    endfunction

endpackage

// File: rtl/nand_bus_sync.sv
module nand_bus_sync
    import nand_pkg::*;
#(
    parameter int NUM_DIES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_DIES-1:0] ce_n_raw,
    input  bus_smp_t            smp_raw,
    output logic [NUM_DIES-1:0] ce_n_s,
    output bus_smp_t            smp_s,
    output bus_evt_t            evt,
    output logic                idle
);

    logic [NUM_DIES-1:0] ce_n_q1, ce_n_q2;
    bus_smp_t            smp_q1, smp_q2;
    logic                re_prev_q, we_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_n_q1   <= '1;
            ce_n_q2   <= '1;
            smp_q1    <= SMP_IDLE;
            smp_q2    <= SMP_IDLE;
            re_prev_q <= 1'b1;
            we_prev_q <= 1'b1;
        end else begin
            ce_n_q1   <= ce_n_raw;
            ce_n_q2   <= ce_n_q1;
            smp_q1    <= smp_raw;
            smp_q2    <= smp_q1;
            re_prev_q <= smp_q2.re_n;
            we_prev_q <= smp_q2.we_n;
        end
    end

    always_comb begin
        evt.we_fall = we_prev_q & ~smp_q2.we_n;
        evt.re_fall = re_prev_q & ~smp_q2.re_n;
        evt.cle     = smp_q2.cle;
        evt.ale     = smp_q2.ale;
        evt.data    = smp_q2.data;
    end

    assign ce_n_s = ce_n_q2;
    assign smp_s  = smp_q2;
    assign idle   = smp_q2.re_n & smp_q2.we_n;

endmodule

// File: rtl/nand_die_mem.sv
module nand_die_mem #(
    parameter int DEPTH = 1584,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0]       mem_q [DEPTH];
    logic [DEPTH-1:0] valid_q;

    always_ff @(posedge clk) begin
        if (wr_en && (32'(wr_addr) < DEPTH)) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en && (32'(wr_addr) < DEPTH)) begin
            valid_q[wr_addr] <= 1'b1;
        end
    end

    always_comb begin
        rd_data = 8'hFF;
        if (32'(rd_addr) < DEPTH) begin
            if (valid_q[rd_addr]) begin
                rd_data = mem_q[rd_addr];
            end
        end
    end

endmodule

// File: rtl/nand_die.sv
module nand_die
    import nand_pkg::*;
#(
    parameter int PAGE_BYTES = 528,
    parameter int DEPTH      = 1584,
    parameter int AW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic          idle,
    input  bus_evt_t      evt,
    output logic [AW-1:0] addr,
    output die_mode_e     mode,
    output logic [1:0]    cyc,
    output logic          ready,
    output logic          read_go,
    output logic          bus_rel,
    output logic          err_evt
);

    localparam int unsigned HI_STEP = PAGE_BYTES * HI_SHIFT;
    localparam logic [1:0]  CYC_LAST = 2'd3;

    die_mode_e     mode_q, mode_d;
    logic [1:0]    cyc_q, cyc_d;
    logic [AW-1:0] addr_q, addr_d;
    logic          ready_q, ready_d;

    always_comb begin
        mode_d  = mode_q;
        cyc_d   = cyc_q;
        addr_d  = addr_q;
        ready_d = ready_q;
        read_go = 1'b0;
        bus_rel = 1'b0;
        err_evt = 1'b0;
        if (sel) begin
            if (idle) begin
                ready_d = 1'b1;
                bus_rel = 1'b1;
            end else begin
                ready_d = 1'b0;
                if (evt.we_fall && evt.re_fall) begin
                    err_evt = 1'b1;
                end else if (evt.we_fall) begin
                    if (evt.cle) begin
                        if (cmd_known(evt.data)) begin
                            mode_d = cmd_mode(evt.data);
                            if (evt.data != CMD_RESET) begin
                                cyc_d = 2'd0;
                            end
                        end else begin
                            err_evt = 1'b1;
                        end
                    end else if (evt.ale) begin
                        if ((mode_q == ST_WAIT) || (cyc_q == CYC_LAST)) begin
                            err_evt = 1'b1;
                        end else begin
                            cyc_d = cyc_q + 2'd1;
                            case (cyc_q)
                                2'd0: addr_d = AW'(add_mod(0,
                                           col_bias(mode_q) + 32'(evt.data), DEPTH));
                                2'd1: addr_d = AW'(add_mod(32'(addr_q),
                                           32'(evt.data) * HI_STEP, DEPTH));
                                default: addr_d = AW'(add_mod(32'(addr_q),
                                           32'(evt.data) * PAGE_BYTES, DEPTH));
                            endcase
                        end
                    end else begin
                        err_evt = 1'b1;
                    end
                end else if (evt.re_fall) begin
                    if (evt.cle || evt.ale) begin
                        err_evt = 1'b1;
                    end else begin
                        read_go = 1'b1;
                        addr_d  = AW'(add_mod(32'(addr_q), 1, DEPTH));
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= ST_WAIT;
            cyc_q   <= 2'd0;
            addr_q  <= '0;
            ready_q <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            cyc_q   <= cyc_d;
            addr_q  <= addr_d;
            ready_q <= ready_d;
        end
    end

    assign addr  = addr_q;
    assign mode  = mode_q;
    assign cyc   = cyc_q;
    assign ready = ready_q;

endmodule

// File: rtl/nand_rd_model.sv
module nand_rd_model
    import nand_pkg::*;
#(
    parameter int NUM_DIES   = 2,
    parameter int PAGE_BYTES = 528,
    parameter int NUM_PAGES  = 3,
    parameter int DEPTH      = PAGE_BYTES * NUM_PAGES,
    parameter int AW         = $clog2(DEPTH),
    parameter int DW         = (NUM_DIES > 1) ? $clog2(NUM_DIES) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_DIES-1:0] ce_n,
    input  logic                cle,
    input  logic                ale,
    input  logic                re_n,
    input  logic                we_n,
    input  logic [7:0]          bus_in,
    output logic [7:0]          bus_out,
    output logic                bus_oe,
    output logic [NUM_DIES-1:0] ready,
    output logic                err,
    input  logic                bd_we,
    input  logic [DW-1:0]       bd_die,
    input  logic [AW-1:0]       bd_addr,
    input  logic [7:0]          bd_data
);

    bus_smp_t            smp_raw, smp_s;
    bus_evt_t            evt;
    logic [NUM_DIES-1:0] ce_n_s;
    logic                idle;

    always_comb begin
        smp_raw.cle  = cle;
        smp_raw.ale  = ale;
        smp_raw.re_n = re_n;
        smp_raw.we_n = we_n;
        smp_raw.data = bus_in;
    end

    nand_bus_sync #(.NUM_DIES(NUM_DIES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .ce_n_raw (ce_n),
        .smp_raw  (smp_raw),
        .ce_n_s   (ce_n_s),
        .smp_s    (smp_s),
        .evt      (evt),
        .idle     (idle)
    );

    // Lowest-numbered enabled die wins.
    logic          sel_valid;
    logic [DW-1:0] sel_idx;
    always_comb begin
        sel_valid = 1'b0;
        sel_idx   = '0;
        for (int i = NUM_DIES - 1; i >= 0; i--) begin
            if (!ce_n_s[i]) begin
                sel_valid = 1'b1;
                sel_idx   = DW'(i);
            end
        end
    end

    logic [NUM_DIES-1:0]          die_read, die_rel, die_err;
    logic [NUM_DIES-1:0][7:0]     die_byte;
    logic [NUM_DIES-1:0][AW-1:0]  die_addr;
    logic [NUM_DIES-1:0][1:0]     die_cyc;
    die_mode_e [NUM_DIES-1:0]     die_mode;

    for (genvar g = 0; g < NUM_DIES; g++) begin : g_die
        logic sel_me;
        logic wr_me;
        assign sel_me = sel_valid && (sel_idx == DW'(g));
        assign wr_me  = bd_we && (bd_die == DW'(g));

        nand_die #(
            .PAGE_BYTES (PAGE_BYTES),
            .DEPTH      (DEPTH),
            .AW         (AW)
        ) u_die (
            .clk     (clk),
            .rst     (rst),
            .sel     (sel_me),
            .idle    (idle),
            .evt     (evt),
            .addr    (die_addr[g]),
            .mode    (die_mode[g]),
            .cyc     (die_cyc[g]),
            .ready   (ready[g]),
            .read_go (die_read[g]),
            .bus_rel (die_rel[g]),
            .err_evt (die_err[g])
        );

        nand_die_mem #(
            .DEPTH (DEPTH),
            .AW    (AW)
        ) u_mem (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_me),
            .wr_addr (bd_addr),
            .wr_data (bd_data),
            .rd_addr (die_addr[g]),
            .rd_data (die_byte[g])
        );
    end

    logic [7:0] rd_byte;
    always_comb begin
        rd_byte = 8'h00;
        for (int i = 0; i < NUM_DIES; i++) begin
            if (die_read[i]) rd_byte = die_byte[i];
        end
    end

    logic [7:0] bus_out_q;
    logic       bus_oe_q, err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_out_q <= 8'h00;
            bus_oe_q  <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            err_q <= |die_err;
            if (|die_read) begin
                bus_out_q <= rd_byte;
                bus_oe_q  <= 1'b1;
            end else if (|die_rel) begin
                bus_oe_q  <= 1'b0;
            end
        end
    end

    assign bus_out = bus_out_q;
    assign bus_oe  = bus_oe_q;
    assign err     = err_q;

endmodule

// File: rtl/nand_rd_model_chk.sv
module nand_rd_model_chk
    import nand_pkg::*;
#(
    parameter int NUM_DIES = 2,
    parameter int DEPTH    = 1584,
    parameter int AW       = $clog2(DEPTH),
    parameter int DW       = 1
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NUM_DIES-1:0]          ready,
    input logic                         bus_oe,
    input logic                         err,
    input logic                         sel_valid,
    input logic [DW-1:0]                sel_idx,
    input logic                         idle,
    input bus_evt_t                     evt,
    input die_mode_e [NUM_DIES-1:0]     die_mode,
    input logic [NUM_DIES-1:0][1:0]     die_cyc,
    input logic [NUM_DIES-1:0][AW-1:0]  die_addr
);

    // R1: nothing moves while no die is enabled
    p_unselected_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !sel_valid |=> ($stable(ready) && $stable(bus_oe) && !err));

    // R2: idle sample with a selected die raises its ready and frees the bus
    p_idle_ready_r2: assert property (@(posedge clk) disable iff (rst)
        (sel_valid && idle) |=> (ready[$past(sel_idx)] && !bus_oe));

    // R3: reset command returns the die to wait
    p_reset_cmd_r3: assert property (@(posedge clk) disable iff (rst)
        (sel_valid && evt.we_fall && !evt.re_fall && evt.cle && evt.data == CMD_RESET)
        |=> (die_mode[$past(sel_idx)] == ST_WAIT));

    // R6: a clean read strobe drives the bus
    p_read_drives_r6: assert property (@(posedge clk) disable iff (rst)
        (sel_valid && evt.re_fall && !evt.we_fall && !evt.cle && !evt.ale)
        |=> bus_oe);

    // R8: an error pulse comes with unchanged die state
    p_err_keeps_state_r8: assert property (@(posedge clk) disable iff (rst)
        err |-> ($stable(die_mode) && $stable(die_cyc) && $stable(die_addr)));

    // R9: address stays inside storage
    for (genvar g = 0; g < NUM_DIES; g++) begin : g_rng
        p_addr_range_r9: assert property (@(posedge clk) disable iff (rst)
            32'(die_addr[g]) < DEPTH);
    end

endmodule

bind nand_rd_model nand_rd_model_chk #(
    .NUM_DIES (NUM_DIES),
    .DEPTH    (DEPTH),
    .AW       (AW),
    .DW       (DW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ready     (ready),
    .bus_oe    (bus_oe),
    .err       (err),
    .sel_valid (sel_valid),
    .sel_idx   (sel_idx),
    .idle      (idle),
    .evt       (evt),
    .die_mode  (die_mode),
    .die_cyc   (die_cyc),
    .die_addr  (die_addr)
);

// File: tb/nand_rd_model_tb.sv
module nand_rd_model_tb;

    localparam int PAGE  = 528;
    localparam int NPG   = 3;
    localparam int DEPTH = PAGE * NPG;
    localparam int AW    = $clog2(DEPTH);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ce_n = 2'b11;
    logic       cle = 1'b0, ale = 1'b0, re_n = 1'b1, we_n = 1'b1;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe, err;
    logic [1:0] ready;
    logic       bd_we = 1'b0;
    logic [0:0] bd_die = 1'b0;
    logic [AW-1:0] bd_addr = '0;
    logic [7:0] bd_data = 8'h00;

    always #2 clk = ~clk;

    nand_rd_model #(.NUM_DIES(2), .PAGE_BYTES(PAGE), .NUM_PAGES(NPG)) u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale),
        .re_n(re_n), .we_n(we_n), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .ready(ready), .err(err), .bd_we(bd_we),
        .bd_die(bd_die), .bd_addr(bd_addr), .bd_data(bd_data)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    string cur_req = "R2";

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", req, $time, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_mem [2][DEPTH];
    int m_mode [2];   // 0 wait, 1..3 read modes
    int m_cyc  [2];
    int m_addr [2];
    int m_rdy  [2];
    int m_oe, m_out, m_err;
    int m_prev_re, m_prev_we;
    int q[$];

    function automatic int pack_in();
        return (int'(ce_n) << 12) | (int'(cle) << 11) | (int'(ale) << 10) |
               (int'(re_n) << 9) | (int'(we_n) << 8) | int'(bus_in);
    endfunction

    function automatic int idle_word();
        return (3 << 12) | (1 << 9) | (1 << 8);
    endfunction

    initial begin
        for (int d = 0; d < 2; d++)
            for (int a = 0; a < DEPTH; a++) m_mem[d][a] = 255;
    end

    task automatic model_reset();
        for (int d = 0; d < 2; d++) begin
            m_mode[d] = 0; m_cyc[d] = 0; m_addr[d] = 0; m_rdy[d] = 0;
        end
        m_oe = 0; m_out = 0; m_err = 0; m_prev_re = 1; m_prev_we = 1;
        q.delete();
        q.push_back(idle_word());
        q.push_back(idle_word());
    endtask

    task automatic model_step(input int s);
        int ce, c, a, rn, wn, b, wf, rf, sel;
        ce = (s >> 12) & 3; c = (s >> 11) & 1; a = (s >> 10) & 1;
        rn = (s >> 9) & 1;  wn = (s >> 8) & 1; b = s & 255;
        wf = m_prev_we & (1 - wn);
        rf = m_prev_re & (1 - rn);
        m_prev_we = wn; m_prev_re = rn;
        m_err = 0;
        sel = ((ce & 1) == 0) ? 0 : (((ce & 2) == 0) ? 1 : -1);
        if (sel < 0) return;
        if (rn == 1 && wn == 1) begin
            m_rdy[sel] = 1; m_oe = 0; return;
        end
        m_rdy[sel] = 0;
        if (wf && rf) m_err = 1;
        else if (wf) begin
            if (c) begin
                if (b == 255) m_mode[sel] = 0;
                else if (b == 0)  begin m_mode[sel] = 1; m_cyc[sel] = 0; end
                else if (b == 1)  begin m_mode[sel] = 2; m_cyc[sel] = 0; end
                else if (b == 80) begin m_mode[sel] = 3; m_cyc[sel] = 0; end
                else m_err = 1;
            end else if (a) begin
                if (m_mode[sel] == 0 || m_cyc[sel] >= 3) m_err = 1;
                else begin
                    if (m_cyc[sel] == 0)
                        m_addr[sel] = (b + (m_mode[sel] == 2 ? 256 : 0) +
                                       (m_mode[sel] == 3 ? 512 : 0)) % DEPTH;
                    else if (m_cyc[sel] == 1)
                        m_addr[sel] = (m_addr[sel] + b * PAGE * 256) % DEPTH;
                    else
                        m_addr[sel] = (m_addr[sel] + b * PAGE) % DEPTH;
                    m_cyc[sel]++;
                end
            end else m_err = 1;
        end else if (rf) begin
            if (c || a) m_err = 1;
            else begin
                m_out = m_mem[sel][m_addr[sel]];
                m_oe  = 1;
                m_addr[sel] = (m_addr[sel] + 1) % DEPTH;
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) model_reset();
        else begin
            if (bd_we) m_mem[bd_die][bd_addr] = bd_data;
            q.push_back(pack_in());
            if (q.size() >= 3) model_step(q.pop_front());
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk({cur_req, " ready"}, ready, (m_rdy[1] << 1) | m_rdy[0]);
            chk({cur_req, " err"}, err, m_err);
            chk({cur_req, " bus_oe"}, bus_oe, m_oe);
            if (m_oe) chk({cur_req, " bus_out"}, bus_out, m_out);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic pulse(input logic [1:0] ce, input logic c, input logic a,
                         input bit use_we, input bit use_re, input logic [7:0] d);
        ce_n = ce; cle = c; ale = a; bus_in = d; re_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        if (use_we) we_n = 1'b0;
        if (use_re) re_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b1; re_n = 1'b1;
        @(negedge clk);
        cle = 1'b0; ale = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cmd(input logic [1:0] ce, input logic [7:0] b);
        pulse(ce, 1'b1, 1'b0, 1'b1, 1'b0, b);
    endtask
    task automatic adr(input logic [1:0] ce, input logic [7:0] b);
        pulse(ce, 1'b0, 1'b1, 1'b1, 1'b0, b);
    endtask
    task automatic rd(input logic [1:0] ce);
        pulse(ce, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    endtask
    task automatic seek(input logic [1:0] ce, input logic [7:0] c,
                        input logic [7:0] a0, input logic [7:0] a1, input logic [7:0] a2);
        cmd(ce, c); adr(ce, a0); adr(ce, a1); adr(ce, a2);
    endtask

    localparam logic [1:0] D0 = 2'b10;
    localparam logic [1:0] D1 = 2'b01;

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (4) @(negedge clk);
        cur_req = "R2";
        chk("R2 reset ready", ready, 0);
        chk("R2 reset bus_oe", bus_oe, 0);
        chk("R2 reset err", err, 0);
        rst = 1'b0;

        // R7: backdoor preload
        cur_req = "R7";
        for (int a = 0; a < 1200; a++) begin
            bd_we = 1'b1; bd_die = 1'b0; bd_addr = AW'(a); bd_data = 8'((a * 7 + 3) & 255);
            @(negedge clk);
        end
        for (int a = 0; a < 600; a++) begin
            bd_we = 1'b1; bd_die = 1'b1; bd_addr = AW'(a); bd_data = 8'(a ^ 8'hA5);
            @(negedge clk);
        end
        bd_we = 1'b0;

        // R2: die 1 idle raises its ready
        cur_req = "R2";
        ce_n = D1; repeat (5) @(negedge clk);
        chk("R2 die1 ready", ready, 2'b10);

        // R3 R4 R5 R6: mode 1, page 1, column 5 -> 533
        cur_req = "R5";
        seek(D0, 8'h00, 8'h05, 8'h00, 8'h01);
        cur_req = "R6";
        for (int i = 0; i < 4; i++) rd(D0);

        // R4: mode 2 bias -> 0x110
        cur_req = "R4";
        seek(D0, 8'h01, 8'h10, 8'h00, 8'h00);
        rd(D0); rd(D0);
        chk("R4 mode2 byte", bus_out, ((16'h111 * 7 + 3) & 255));

        // R6: mode 3 column 0x20F crosses page boundary
        cur_req = "R6";
        seek(D0, 8'h50, 8'h0F, 8'h00, 8'h00);
        for (int i = 0; i < 3; i++) rd(D0);
        chk("R6 cross page", bus_out, ((529 * 7 + 3) & 255));

        // R5: high page byte
        cur_req = "R5";
        seek(D0, 8'h00, 8'h03, 8'h01, 8'h00);
        rd(D0); rd(D0);

        // R7: unwritten reads 0xFF
        cur_req = "R7";
        seek(D1, 8'h00, 8'h00, 8'h00, 8'h02);
        rd(D1);
        chk("R7 unwritten", bus_out, 8'hFF);

        // R1: park die 1 at 32, then drive with both enables low
        cur_req = "R1";
        seek(D1, 8'h00, 8'h20, 8'h00, 8'h00);
        seek(2'b00, 8'h00, 8'h00, 8'h00, 8'h00);
        rd(2'b00); rd(2'b00);
        chk("R1 priority die0", bus_out, ((1 * 7 + 3) & 255));
        rd(D1);
        chk("R1 die1 untouched", bus_out, (32 ^ 8'hA5));
        // R1: nothing selected
        cmd(2'b11, 8'hFF); rd(2'b11);
        rd(D0);
        chk("R1 none selected", bus_out, ((2 * 7 + 3) & 255));

        // R8: error cases
        cur_req = "R8";
        cmd(D0, 8'h30);
        adr(D0, 8'h07);
        rd(D0);
        chk("R8 state kept", bus_out, ((3 * 7 + 3) & 255));
        pulse(D0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
        pulse(D0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h12);
        pulse(D0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
        rd(D0);
        chk("R8 addr kept", bus_out, ((4 * 7 + 3) & 255));
        cmd(D0, 8'hFF);
        adr(D0, 8'h01);

        // R9: wrap at DEPTH-1 and via page multiples
        cur_req = "R9";
        seek(D0, 8'h50, 8'h0F, 8'h00, 8'h02);
        rd(D0); rd(D0);
        chk("R9 wrap to zero", bus_out, 3);
        seek(D0, 8'h00, 8'h04, 8'h02, 8'h03);
        rd(D0);

        // R10: three-edge latency
        cur_req = "R10";
        ce_n = D0; cle = 1'b0; ale = 1'b0; re_n = 1'b1; we_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 idle before", bus_oe, 0);
        re_n = 1'b0;
        @(negedge clk); chk("R10 edge1", bus_oe, 0);
        @(negedge clk); chk("R10 edge2", bus_oe, 0);
        @(negedge clk); chk("R10 edge3", bus_oe, 1);
        re_n = 1'b1;
        repeat (4) @(negedge clk);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule